// File: doc/BRIEF.md
# Packing Read Buffer for a Line-Fill Bus Interface

This block is the receive half of a bus interface unit. It serves two read kinds: a single-word read and a block read of one cache line (four 32-bit words by default). External memory may be 8, 16 or 32 bits wide. Narrow bus beats are assembled into full 32-bit words inside the block, so a narrow boot ROM or peripheral needs no external packing logic. The same logic serves instruction and data reads.

For a block read, every assembled word is written into a line-sized staging buffer. Nothing is handed to the requester until the whole line has been collected. The line is then released as a back-to-back burst, one word per clock. A single-word read bypasses the buffer and returns its word as soon as the last beat of that word arrives.

The external side has two timing modes. In handshake mode, every beat is qualified by an acknowledge. In burst mode, only the first beat needs the acknowledge, and memory then supplies one beat on every clock until the line is complete.

Top module: `line_fill_packer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `busy`, `out_valid`, `out_last` and `done` are low. A reset during a fill abandons it without producing any output.
- R2: A `req_valid` seen while `busy` is low latches the request and raises `busy` on the next cycle. The request fields are: `req_quad` (1 = line read, 0 = single word), `req_width` (2'b00 = 8-bit, 2'b01 = 16-bit, 2'b10 = 32-bit port) and `req_burst`. A `req_valid` seen while `busy` is high is ignored and does not change the read in progress.
- R3: An 8-bit port takes four beats per word from `ext_data[7:0]`. A 16-bit port takes two beats per word from `ext_data[15:0]`. A 32-bit port takes one beat. Data lanes outside the port width have no effect.
- R4: Packing is little-endian. Beat k of a word fills byte k (bits 8k+7:8k) on an 8-bit port, or halfword k (bits 16k+15:16k) on a 16-bit port.
- R5: In handshake mode, a beat is taken only in a cycle with `ext_ack` high. Cycles with `ext_ack` low leave the result unchanged, whatever is on `ext_data`.
- R6: In burst mode on a line read, the first beat is taken with `ext_ack`. Each following cycle then takes one beat, whatever the level of `ext_ack`, until the line is complete.
- R7: A single-word read presents its word with `out_valid` and `out_last` high for exactly one cycle. This happens in the cycle after its final beat. `req_burst` has no effect on a single-word read.
- R8: A line read presents no output until all its words are stored. Starting in the cycle after the final beat, it then presents the words on consecutive cycles, lowest address first, with `out_last` high only on the final word.
- R9: `done` is a one-cycle pulse. It coincides with the first word presented for the read: the only word of a single read, or word 0 of a line.
- R10: After the last word has been presented, `busy` is low and a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a read (taken only while idle) |
| req_quad | input | 1 | 1 = line read, 0 = single-word read |
| req_width | input | 2 | Port width: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit |
| req_burst | input | 1 | 1 = clock-rate burst timing for line reads |
| busy | output | 1 | A read is being collected or released |
| ext_ack | input | 1 | Beat acknowledge from memory |
| ext_data | input | 32 | Beat data from memory (narrow ports use the low lanes) |
| out_valid | output | 1 | `out_data` holds a returned word |
| out_data | output | 32 | Returned word |
| out_last | output | 1 | Final word of the read |
| done | output | 1 | One-cycle pulse marking the start of release |

## Verification
The bench builds the block with its default line of four words. With a two-bit write pointer, that line size makes an 8-bit-port line read take sixteen beats, which exercises every byte lane, every buffer entry and the pointer wrap. The stimulus table covers all three port widths in both read kinds, with idle gaps under handshake timing and with the acknowledge dropped during a clock-rate burst. Junk placed on unused lanes and in gap cycles exposes any beat taken at the wrong time or from the wrong lane.

// File: rtl/lfp_pkg.sv
package lfp_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        PW8  = 2'b00,
        PW16 = 2'b01,
        PW32 = 2'b10
    } port_w_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_DRAIN
    } lfp_state_e;

    typedef struct packed {
        logic    quad;
        port_w_e width;
        logic    burst;
    } lfp_req_t;

    // index of the final beat inside one word for a given port width
    function automatic logic [1:0] last_beat(port_w_e w);
        case (w)
            PW8:     return 2'd3;
            PW16:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    // place one beat into its little-endian lane of the partial word
    function automatic logic [WORD_W-1:0] merge_beat(logic [WORD_W-1:0] acc,
                                                     logic [WORD_W-1:0] beat,
                                                     port_w_e w,
                                                     logic [1:0] idx);
        logic [WORD_W-1:0] r;
        r = acc;
        case (w)
            PW8:     r[{idx, 3'b000} +: 8]    = beat[7:0];
            PW16:    r[{idx[0], 4'b0000} +: 16] = beat[15:0];
            default: r = beat;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lfp_beat_packer.sv
module lfp_beat_packer
    import lfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              accept,
    input  port_w_e           width,
    input  logic [WORD_W-1:0] beat,
    output logic              word_done,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] acc;
    logic [1:0]        cnt;

    assign word      = merge_beat(acc, beat, width, cnt);
    assign word_done = accept && (cnt == last_beat(width));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
            cnt <= '0;
        end else if (accept) begin
            if (word_done) begin
                acc <= '0;
                cnt <= '0;
            end else begin
                acc <= word;
                cnt <= cnt + 2'd1;
            end
        end
    end

endmodule

// File: rtl/lfp_line_buffer.sv
module lfp_line_buffer
    import lfp_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PTR_W = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PTR_W'(i))) begin
                mem[i] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/line_fill_packer.sv
module line_fill_packer
    import lfp_pkg::*;
#(
    parameter int LINE_WORDS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_quad,
    input  logic [1:0]  req_width,
    input  logic        req_burst,
    output logic        busy,
    input  logic        ext_ack,
    input  logic [31:0] ext_data,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic        out_last,
    output logic        done
);

    localparam int PTR_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(LINE_WORDS - 1);

    lfp_state_e        st;
    lfp_req_t          cur;
    logic              streaming;
    logic [PTR_W-1:0]  wr_idx;
    logic [PTR_W-1:0]  rd_idx;
    logic              sgl_valid_q;
    logic [WORD_W-1:0] sgl_data_q;
    logic              done_q;

    logic              accept;
    logic              word_done;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] line_rd;

    assign accept = (st == ST_FILL) && (ext_ack || streaming);

    lfp_beat_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .clear     (st == ST_IDLE),
        .accept    (accept),
        .width     (cur.width),
        .beat      (ext_data),
        .word_done (word_done),
        .word      (word)
    );

    lfp_line_buffer #(
        .DEPTH (LINE_WORDS),
        .PTR_W (PTR_W)
    ) u_line (
        .clk     (clk),
        .wr_en   (word_done && cur.quad),
        .wr_idx  (wr_idx),
        .wr_data (word),
        .rd_idx  (rd_idx),
        .rd_data (line_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cur         <= '{quad: 1'b0, width: PW32, burst: 1'b0};
            streaming   <= 1'b0;
            wr_idx      <= '0;
            rd_idx      <= '0;
            sgl_valid_q <= 1'b0;
            sgl_data_q  <= '0;
            done_q      <= 1'b0;
        end else begin
            sgl_valid_q <= 1'b0;
            done_q      <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur       <= '{quad: req_quad, width: port_w_e'(req_width), burst: req_burst};
                        st        <= ST_FILL;
                        wr_idx    <= '0;
                        streaming <= 1'b0;
                    end
                end
                ST_FILL: begin
                    if (accept && cur.quad && cur.burst) begin
                        streaming <= 1'b1;
                    end
                    if (word_done) begin
                        if (!cur.quad) begin
                            sgl_valid_q <= 1'b1;
                            sgl_data_q  <= word;
                            done_q      <= 1'b1;
                            streaming   <= 1'b0;
                            st          <= ST_IDLE;
                        end else if (wr_idx == LAST_IDX) begin
                            done_q    <= 1'b1;
                            rd_idx    <= '0;
                            streaming <= 1'b0;
                            st        <= ST_DRAIN;
                        end else begin
                            wr_idx <= wr_idx + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    rd_idx <= rd_idx + 1'b1;
                    if (rd_idx == LAST_IDX) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign out_valid = sgl_valid_q || (st == ST_DRAIN);
    assign out_data  = (st == ST_DRAIN) ? line_rd : sgl_data_q;
    assign out_last  = sgl_valid_q || ((st == ST_DRAIN) && (rd_idx == LAST_IDX));
    assign done      = done_q;

endmodule

// File: rtl/line_fill_packer_chk.sv
module line_fill_packer_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic out_valid,
    input logic out_last,
    input logic done
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !out_valid && !out_last && !done));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy);

    // R8
    last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R8
    release_contiguous_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    // R9
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_with_word_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> out_valid);

    // R10
    idle_after_line_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last && busy) |=> !busy);

endmodule

bind line_fill_packer line_fill_packer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_last  (out_last),
    .done      (done)
);

// File: tb/line_fill_packer_tb.sv
`timescale 1ns/1ps
module line_fill_packer_tb;

    localparam int LW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_quad = 1'b0;
    logic [1:0]  req_width = 2'b00;
    logic        req_burst = 1'b0;
    logic        busy;
    logic        ext_ack = 1'b0;
    logic [31:0] ext_data = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_last;
    logic        done;

    line_fill_packer #(.LINE_WORDS(LW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_quad(req_quad),
        .req_width(req_width), .req_burst(req_burst), .busy(busy),
        .ext_ack(ext_ack), .ext_data(ext_data), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .done(done)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic [31:0] cap_data [8];
    logic        cap_last [8];
    int          cap_cyc  [8];
    int          cap_n;
    int          done_n;
    int          done_cyc;

    typedef struct packed {
        logic        quad;
        logic [1:0]  width;
        logic        burst;
        logic [15:0] gaps;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 1'b0, 16'h0005, 8'h11},
        '{1'b0, 2'd1, 1'b0, 16'h0000, 8'h22},
        '{1'b0, 2'd2, 1'b0, 16'h0001, 8'h33},
        '{1'b1, 2'd0, 1'b0, 16'h8421, 8'h44},
        '{1'b1, 2'd1, 1'b0, 16'h00A5, 8'h55},
        '{1'b1, 2'd2, 1'b0, 16'h0003, 8'h66},
        '{1'b1, 2'd0, 1'b1, 16'h0001, 8'h77},
        '{1'b0, 2'd0, 1'b1, 16'h0002, 8'h88},
        '{1'b1, 2'd1, 1'b1, 16'h0000, 8'h99}
    };

    function automatic logic [31:0] beat_val(logic [7:0] seed, int n);
        logic [7:0] nb;
        nb = 8'(n);
        return {seed ^ 8'hA5, nb + 8'h40, seed + nb + 8'h11, seed + 8'(3 * n)};
    endfunction

    function automatic logic [31:0] exp_word(logic [1:0] w, logic [7:0] seed, int k);
        logic [31:0] r;
        logic [31:0] b;
        r = '0;
        case (w)
            2'd0: for (int i = 0; i < 4; i++) begin
                      b = beat_val(seed, 4 * k + i);
                      r[8 * i +: 8] = b[7:0];
                  end
            2'd1: for (int i = 0; i < 2; i++) begin
                      b = beat_val(seed, 2 * k + i);
                      r[16 * i +: 16] = b[15:0];
                  end
            default: r = beat_val(seed, k);
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // wait to the next falling edge and record what the block presents there
    task automatic step();
        @(negedge clk);
        cyc++;
        if (out_valid) begin
            if (cap_n < 8) begin
                cap_data[cap_n] = out_data;
                cap_last[cap_n] = out_last;
                cap_cyc[cap_n]  = cyc;
            end
            cap_n++;
        end
        if (done) begin
            done_n++;
            done_cyc = cyc;
        end
    endtask

    task automatic run_read(logic quad, logic [1:0] width, logic burst,
                            logic [15:0] gaps, logic [7:0] seed, bit hold_req,
                            string tag);
        int bpw;
        int nw;
        int nb;
        int pre;
        bit stream;
        bpw = (width == 2'd0) ? 4 : (width == 2'd1) ? 2 : 1;
        nw  = quad ? LW : 1;
        nb  = nw * bpw;
        stream = quad && burst;
        pre = 0;
        cap_n = 0;
        done_n = 0;
        done_cyc = -1;
        req_valid = 1'b1;
        req_quad  = quad;
        req_width = width;
        req_burst = burst;
        step();
        req_valid = hold_req;
        req_quad  = !quad;
        req_width = (width == 2'd0) ? 2'd2 : 2'd0;
        req_burst = !burst;
        for (int b = 0; b < nb; b++) begin
            if ((!stream || b == 0) && b < 16 && gaps[b]) begin
                ext_ack  = 1'b0;
                ext_data = 32'hDEAD_BEEF ^ 32'(b);
                step();
            end
            ext_ack  = (stream && b > 0) ? 1'b0 : 1'b1;
            ext_data = beat_val(seed, b);
            if (b == nb - 1) pre = cap_n;
            step();
        end
        ext_ack   = 1'b0;
        ext_data  = 32'hBAD0_CAFE;
        req_valid = 1'b0;
        for (int i = 0; i < LW + 2; i++) step();

        // R8: nothing released before the fill completes
        check({tag, " R8 early-output"}, 32'(pre), 32'd0);
        // R7 R8: word count
        check({tag, " R7/R8 word-count"}, 32'(cap_n), 32'(nw));
        for (int k = 0; k < nw && k < 8; k++) begin
            // R3 R4 R5 R6: packed word contents
            check($sformatf("%s R4 word%0d", tag, k), cap_data[k], exp_word(width, seed, k));
            check($sformatf("%s R8 last%0d", tag, k), 32'(cap_last[k]), 32'(k == nw - 1));
            if (k > 0)
                check($sformatf("%s R8 back-to-back%0d", tag, k), 32'(cap_cyc[k] - cap_cyc[k-1]), 32'd1);
        end
        // R9: one done pulse, with the first word
        check({tag, " R9 done-count"}, 32'(done_n), 32'd1);
        check({tag, " R9 done-cycle"}, 32'(done_cyc), 32'(cap_cyc[0]));
        // R10: idle again
        check({tag, " R10 busy-low"}, 32'(busy), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        cap_n = 0;
        done_n = 0;
        done_cyc = -1;
        rst = 1'b1;
        repeat (3) step();
        // R1: quiet during reset
        check("R1 busy in reset", 32'(busy), 32'd0);
        check("R1 valid in reset", 32'(out_valid), 32'd0);
        check("R1 done in reset", 32'(done), 32'd0);
        rst = 1'b0;
        step();
        check("R1 idle after reset", {29'd0, busy, out_valid, out_last}, 32'd0);

        // table walk: widths, read kinds, handshake gaps, burst timing
        for (int v = 0; v < NV; v++) begin
            run_read(VEC[v].quad, VEC[v].width, VEC[v].burst, VEC[v].gaps,
                     VEC[v].seed, 1'b0, $sformatf("vec%0d", v));
        end

        // R2: request fields changed and held while busy are ignored
        run_read(1'b0, 2'd1, 1'b0, 16'h0002, 8'h5A, 1'b1, "R2 hold-req");

        // R1: reset in the middle of a line fill
        cap_n = 0;
        done_n = 0;
        req_valid = 1'b1; req_quad = 1'b1; req_width = 2'd0; req_burst = 1'b0;
        step();
        req_valid = 1'b0;
        for (int b = 0; b < 3; b++) begin
            ext_ack = 1'b1;
            ext_data = 32'h1000_0000 + 32'(b);
            step();
        end
        ext_ack = 1'b0;
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        check("R1 mid-fill busy", 32'(busy), 32'd0);
        check("R1 mid-fill no output", 32'(cap_n + done_n), 32'd0);
        // R1 R10: clean line read after the abandoned fill
        run_read(1'b1, 2'd0, 1'b0, 16'h0000, 8'hC3, 1'b0, "R1 post-reset");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule